// File: doc/BRIEF.md
# Trace capture circular buffer controller

This block records a stream of 32-bit trace words into an on-chip RAM and lets software configure it and read the result back through a small register bus. In circular mode every valid word goes to the write pointer, which advances and wraps at the buffer depth. The stream therefore always holds the most recent words.

Capture can end in two ways. Software can request a manual flush. Or a trigger input can be armed, so that after a programmable number of further words a flush starts by itself. With stop-on-flush set, the end of the flush halts capture and raises the ready status. Software then pulls the words out of the read-data register one per read, oldest first. If the pointer wrapped, readback starts at the write pointer. If it did not, readback starts at address 0. Once every valid word has been read, a read returns all ones.

Register reads return their data on `reg_rdata_o` in the cycle after `reg_rd_i`. The register map, as byte offsets, is:

| Offset | Register |
|---|---|
| 0x00 | depth |
| 0x04 | status |
| 0x08 | read data |
| 0x0C | read pointer |
| 0x10 | write pointer |
| 0x14 | post-trigger count |
| 0x18 | control |
| 0x1C | mode |
| 0x20 | flush control |

Top module: `trace_buf_ctrl`

## Requirements
- R1: The depth register (0x00) reads back the buffer depth in 32-bit words, so the byte capacity is four times this value. Every register read returns its value one clock after the read strobe.
- R2: After reset, these read as zero: the write pointer, the read pointer, the control register, the wrapped flag (status bit 0) and the triggered flag (status bit 1). The ready flag (status bit 2) reads 1.
- R3: A valid trace word is stored only while control bit 0 is 1 and the mode register holds 0 (circular). Mode 1 is software FIFO and mode 2 is hardware FIFO; in those modes no word is stored and the write pointer does not move.
- R4: When the write pointer passes the last address it returns to 0 and status bit 0 sets and stays set. A later readback then starts at the write pointer and returns the full depth of words, oldest first.
- R5: Without a wrap, readback starts at address 0 and returns exactly as many words as the write pointer value, in capture order.
- R6: A read of the read-data register returns 0xFFFFFFFF, and leaves the read pointer unchanged, in two cases: all valid words have already been read, or capture is still running.
- R7: Writing 1 to flush-control bit 6 starts a manual flush, and the bit clears itself when the flush ends. If stop-on-flush (bit 12) is set, capture halts at that point. If bit 12 is clear, capture continues afterwards.
- R8: While capture runs and flush-control bit 8 is set, a high trigger input sets status bit 1. If bit 8 is clear, the trigger input is ignored.
- R9: After a trigger, exactly the post-trigger count (0x14) of further valid words is stored, and later words are dropped. When the count runs out and flush-control bit 5 is set, a flush starts; together with bit 12 this halts capture.
- R10: Status bit 2 (ready) is 0 while capture runs. It becomes 1 once capture is halted or disabled and readback is set up.
- R11: Setting control bit 0 from 0 to 1 clears the triggered flag and resumes capture at the current write pointer.
- R12: Each read that returns a stored word advances the read pointer by one, modulo the depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 8 | Register byte address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, valid one cycle after the strobe |
| trace_valid_i | input | 1 | Trace word valid |
| trace_data_i | input | 32 | Trace word |
| trig_i | input | 1 | Trigger input |

## Verification
The hardest case to reach is a readback after a wrap that was ended by the trigger path. It combines a write pointer that has lapped the buffer, a trigger that lands mid-stream, a post-trigger count that must cut off surplus words, and a flush that stops capture without any software flush write. The stimulus first leaves a partial linear capture in place. It then re-enables capture and streams enough words to lap the 16-word buffer. Next it fires the trigger on one word and offers twice the post-trigger count of further words. Finally it reads the whole depth, expecting a single ascending sequence that starts at the write pointer.

// File: rtl/trace_buf_pkg.sv
package trace_buf_pkg;

  localparam int DW = 32;

  // word offsets on the register bus (byte address / 4)
  localparam logic [5:0] OFS_DEPTH   = 6'd0;
  localparam logic [5:0] OFS_STAT    = 6'd1;
  localparam logic [5:0] OFS_RDATA   = 6'd2;
  localparam logic [5:0] OFS_RPTR    = 6'd3;
  localparam logic [5:0] OFS_WPTR    = 6'd4;
  localparam logic [5:0] OFS_TRIGCNT = 6'd5;
  localparam logic [5:0] OFS_CTRL    = 6'd6;
  localparam logic [5:0] OFS_MODE    = 6'd7;
  localparam logic [5:0] OFS_FLUSH   = 6'd8;

  // flush control bit positions
  localparam int FL_TRIG_FLUSH = 5;
  localparam int FL_MANUAL     = 6;
  localparam int FL_TRIG_IN    = 8;
  localparam int FL_STOP       = 12;

  // status bit positions
  localparam int ST_WRAP  = 0;
  localparam int ST_TRIG  = 1;
  localparam int ST_READY = 2;

  typedef enum logic [1:0] {
    MODE_CIRC   = 2'd0,
    MODE_SWFIFO = 2'd1,
    MODE_HWFIFO = 2'd2,
    MODE_RSVD   = 2'd3
  } cap_mode_e;

endpackage

// File: rtl/trace_buf_ram.sv
module trace_buf_ram #(
  parameter int DEPTH = 64,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end

endmodule

// File: rtl/trace_buf_core.sv
module trace_buf_core
  import trace_buf_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctrl_en_i,
  input  cap_mode_e     mode_i,
  input  logic          en_rise_i,
  input  logic          man_flush_i,
  input  logic          sof_i,
  input  logic          fot_i,
  input  logic          trig_in_en_i,
  input  logic [31:0]   trig_cnt_i,
  input  logic          trace_valid_i,
  input  logic [DW-1:0] trace_data_i,
  input  logic          trig_i,
  input  logic          rd_pop_i,
  output logic          flush_done_o,
  output logic          wrapped_o,
  output logic          triggered_o,
  output logic          ready_o,
  output logic [AW-1:0] wr_ptr_o,
  output logic [AW-1:0] rd_ptr_o,
  output logic          ram_we_o,
  output logic [AW-1:0] ram_waddr_o,
  output logic [DW-1:0] ram_wdata_o,
  output logic          ram_re_o,
  output logic [AW-1:0] ram_raddr_o
);

  localparam logic [AW-1:0] LAST    = AW'(DEPTH - 1);
  localparam logic [AW:0]   DEPTH_W = (AW+1)'(DEPTH);

  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [AW:0]   rd_left_q;
  logic          wrapped_q, triggered_q, evt_fired_q, flush_busy_q;
  logic          stopped_q, rd_loaded_q;
  logic [31:0]   post_cnt_q;

  logic running, post_done, cap_en, wr_en, trig_hit, evt_hit, flush_start, rd_ok;

  assign running     = ctrl_en_i && (mode_i == MODE_CIRC) && !stopped_q;
  assign post_done   = triggered_q && (post_cnt_q == '0);
  assign cap_en      = running && !flush_busy_q && !post_done;
  assign wr_en       = cap_en && trace_valid_i;
  assign trig_hit    = cap_en && trig_i && trig_in_en_i && !triggered_q;
  assign evt_hit     = running && post_done && !evt_fired_q && !flush_busy_q;
  assign flush_start = !flush_busy_q && (man_flush_i || (evt_hit && fot_i));
  assign rd_ok       = rd_pop_i && rd_loaded_q && (rd_left_q != '0);

  // capture side
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q     <= '0;
      wrapped_q    <= 1'b0;
      triggered_q  <= 1'b0;
      post_cnt_q   <= '0;
      evt_fired_q  <= 1'b0;
      flush_busy_q <= 1'b0;
      stopped_q    <= 1'b0;
    end else begin
      if (wr_en) begin
        if (wr_ptr_q == LAST) begin
          wr_ptr_q  <= '0;
          wrapped_q <= 1'b1;
        end else begin
          wr_ptr_q <= wr_ptr_q + 1'b1;
        end
      end

      if (en_rise_i)     triggered_q <= 1'b0;
      else if (trig_hit) triggered_q <= 1'b1;

      if (trig_hit)
        post_cnt_q <= trig_cnt_i;
      else if (triggered_q && (post_cnt_q != '0) && wr_en)
        post_cnt_q <= post_cnt_q - 1'b1;

      if (en_rise_i)    evt_fired_q <= 1'b0;
      else if (evt_hit) evt_fired_q <= 1'b1;

      if (flush_start)       flush_busy_q <= 1'b1;
      else if (flush_busy_q) flush_busy_q <= 1'b0;

      if (en_rise_i)                 stopped_q <= 1'b0;
      else if (flush_busy_q && sof_i) stopped_q <= 1'b1;
    end
  end

  // readback side: set up once capture is no longer running
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_loaded_q <= 1'b0;
      rd_ptr_q    <= '0;
      rd_left_q   <= '0;
    end else if (running) begin
      rd_loaded_q <= 1'b0;
    end else if (!rd_loaded_q) begin
      rd_loaded_q <= 1'b1;
      rd_ptr_q    <= wrapped_q ? wr_ptr_q : '0;
      rd_left_q   <= wrapped_q ? DEPTH_W : {1'b0, wr_ptr_q};
    end else if (rd_ok) begin
      rd_ptr_q  <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      rd_left_q <= rd_left_q - 1'b1;
    end
  end

  assign flush_done_o = flush_busy_q;
  assign wrapped_o    = wrapped_q;
  assign triggered_o  = triggered_q;
  assign ready_o      = !running && rd_loaded_q && !flush_busy_q;
  assign wr_ptr_o     = wr_ptr_q;
  assign rd_ptr_o     = rd_ptr_q;
  assign ram_we_o     = wr_en;
  assign ram_waddr_o  = wr_ptr_q;
  assign ram_wdata_o  = trace_data_i;
  assign ram_re_o     = rd_ok;
  assign ram_raddr_o  = rd_ptr_q;

  a_r3_idle_no_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running |=> $stable(wr_ptr_q));

  a_r4_wrap_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrapped_q |=> wrapped_q);

  a_r9_post_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    post_done |=> $stable(wr_ptr_q));

  a_r7_flush_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_busy_q |=> !flush_busy_q);

  a_r7_stop_on_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_busy_q && sof_i && !en_rise_i) |=> stopped_q);

  a_r6_empty_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_pop_i && rd_loaded_q && (rd_left_q == '0)) |=> $stable(rd_ptr_q));

endmodule

// File: rtl/trace_buf_regs.sv
module trace_buf_regs
  import trace_buf_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    reg_addr_i,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  input  logic          flush_done_i,
  input  logic          wrapped_i,
  input  logic          triggered_i,
  input  logic          ready_i,
  input  logic [AW-1:0] wr_ptr_i,
  input  logic [AW-1:0] rd_ptr_i,
  input  logic          ram_re_i,
  input  logic [DW-1:0] ram_rdata_i,
  output logic          ctrl_en_o,
  output cap_mode_e     mode_o,
  output logic          fot_o,
  output logic          man_flush_o,
  output logic          trig_in_en_o,
  output logic          sof_o,
  output logic [31:0]   trig_cnt_o,
  output logic          en_rise_o,
  output logic          rd_pop_o
);

  logic [5:0]  widx;
  logic        hit, wr_hit, rd_hit;
  logic [31:0] rd_val, rdata_q;
  logic        sel_ram_q;
  logic        ctrl_en_q, fot_q, man_q, trig_in_q, sof_q;
  cap_mode_e   mode_q;
  logic [31:0] trig_cnt_q;

  assign widx   = reg_addr_i[7:2];
  assign hit    = (reg_addr_i[1:0] == 2'b00);
  assign wr_hit = reg_wr_i && hit;
  assign rd_hit = reg_rd_i && hit;

  assign en_rise_o = wr_hit && (widx == OFS_CTRL) && reg_wdata_i[0] && !ctrl_en_q;
  assign rd_pop_o  = rd_hit && (widx == OFS_RDATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_en_q  <= 1'b0;
      mode_q     <= MODE_CIRC;
      fot_q      <= 1'b0;
      man_q      <= 1'b0;
      trig_in_q  <= 1'b0;
      sof_q      <= 1'b0;
      trig_cnt_q <= '0;
    end else begin
      if (flush_done_i) man_q <= 1'b0;
      if (wr_hit) begin
        unique case (widx)
          OFS_CTRL:    ctrl_en_q  <= reg_wdata_i[0];
          OFS_MODE:    mode_q     <= cap_mode_e'(reg_wdata_i[1:0]);
          OFS_TRIGCNT: trig_cnt_q <= reg_wdata_i;
          OFS_FLUSH: begin
            fot_q     <= reg_wdata_i[FL_TRIG_FLUSH];
            trig_in_q <= reg_wdata_i[FL_TRIG_IN];
            sof_q     <= reg_wdata_i[FL_STOP];
            if (reg_wdata_i[FL_MANUAL]) man_q <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_val = '0;
    unique case (widx)
      OFS_DEPTH:   rd_val = 32'(DEPTH);
      OFS_STAT: begin
        rd_val[ST_WRAP]  = wrapped_i;
        rd_val[ST_TRIG]  = triggered_i;
        rd_val[ST_READY] = ready_i;
      end
      OFS_RDATA:   rd_val = '1;
      OFS_RPTR:    rd_val = 32'(rd_ptr_i);
      OFS_WPTR:    rd_val = 32'(wr_ptr_i);
      OFS_TRIGCNT: rd_val = trig_cnt_q;
      OFS_CTRL:    rd_val[0] = ctrl_en_q;
      OFS_MODE:    rd_val[1:0] = mode_q;
      OFS_FLUSH: begin
        rd_val[FL_TRIG_FLUSH] = fot_q;
        rd_val[FL_MANUAL]     = man_q;
        rd_val[FL_TRIG_IN]    = trig_in_q;
        rd_val[FL_STOP]       = sof_q;
      end
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q   <= '0;
      sel_ram_q <= 1'b0;
    end else if (rd_hit) begin
      rdata_q   <= rd_val;
      sel_ram_q <= ram_re_i;
    end
  end

  assign reg_rdata_o  = sel_ram_q ? ram_rdata_i : rdata_q;
  assign ctrl_en_o    = ctrl_en_q;
  assign mode_o       = mode_q;
  assign fot_o        = fot_q;
  assign man_flush_o  = man_q;
  assign trig_in_en_o = trig_in_q;
  assign sof_o        = sof_q;
  assign trig_cnt_o   = trig_cnt_q;

  a_r7_manual_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_done_i && !(wr_hit && (widx == OFS_FLUSH))) |=> !man_q);

  a_r12_pop_only_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_re_i |-> rd_pop_o);

endmodule

// File: rtl/trace_buf_ctrl.sv
module trace_buf_ctrl
  import trace_buf_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  reg_addr_i,
  input  logic        reg_wr_i,
  input  logic        reg_rd_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        trace_valid_i,
  input  logic [31:0] trace_data_i,
  input  logic        trig_i
);

  localparam int AW = $clog2(DEPTH);

  logic          ctrl_en, fot, man_flush, trig_in_en, sof, en_rise, rd_pop;
  cap_mode_e     mode;
  logic [31:0]   trig_cnt;
  logic          flush_done, wrapped, triggered, ready;
  logic [AW-1:0] wr_ptr, rd_ptr, ram_waddr, ram_raddr;
  logic          ram_we, ram_re;
  logic [DW-1:0] ram_wdata, ram_rdata;

  trace_buf_regs #(.DEPTH(DEPTH)) u_regs (
    .clk_i, .rst_ni, .reg_addr_i, .reg_wr_i, .reg_rd_i, .reg_wdata_i, .reg_rdata_o,
    .flush_done_i (flush_done),
    .wrapped_i    (wrapped),
    .triggered_i  (triggered),
    .ready_i      (ready),
    .wr_ptr_i     (wr_ptr),
    .rd_ptr_i     (rd_ptr),
    .ram_re_i     (ram_re),
    .ram_rdata_i  (ram_rdata),
    .ctrl_en_o    (ctrl_en),
    .mode_o       (mode),
    .fot_o        (fot),
    .man_flush_o  (man_flush),
    .trig_in_en_o (trig_in_en),
    .sof_o        (sof),
    .trig_cnt_o   (trig_cnt),
    .en_rise_o    (en_rise),
    .rd_pop_o     (rd_pop)
  );

  trace_buf_core #(.DEPTH(DEPTH)) u_core (
    .clk_i, .rst_ni,
    .ctrl_en_i     (ctrl_en),
    .mode_i        (mode),
    .en_rise_i     (en_rise),
    .man_flush_i   (man_flush),
    .sof_i         (sof),
    .fot_i         (fot),
    .trig_in_en_i  (trig_in_en),
    .trig_cnt_i    (trig_cnt),
    .trace_valid_i,
    .trace_data_i,
    .trig_i,
    .rd_pop_i      (rd_pop),
    .flush_done_o  (flush_done),
    .wrapped_o     (wrapped),
    .triggered_o   (triggered),
    .ready_o       (ready),
    .wr_ptr_o      (wr_ptr),
    .rd_ptr_o      (rd_ptr),
    .ram_we_o      (ram_we),
    .ram_waddr_o   (ram_waddr),
    .ram_wdata_o   (ram_wdata),
    .ram_re_o      (ram_re),
    .ram_raddr_o   (ram_raddr)
  );

  trace_buf_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
    .clk_i, .rst_ni,
    .we_i    (ram_we),
    .waddr_i (ram_waddr),
    .wdata_i (ram_wdata),
    .re_i    (ram_re),
    .raddr_i (ram_raddr),
    .rdata_o (ram_rdata)
  );

endmodule

// File: tb/trace_buf_ctrl_tb.sv
module trace_buf_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TB_DEPTH   = 16;
  localparam int WD_CYCLES  = 50000;

  localparam logic [7:0] A_DEPTH = 8'h00, A_STAT = 8'h04, A_RDATA = 8'h08,
                         A_RPTR = 8'h0C, A_WPTR = 8'h10, A_TCNT = 8'h14,
                         A_CTRL = 8'h18, A_MODE = 8'h1C, A_FLUSH = 8'h20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tvalid = 1'b0;
  logic [31:0] tdata = '0;
  logic        trig = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  trace_buf_ctrl #(.DEPTH(TB_DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_addr_i(reg_addr), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .trace_valid_i(tvalid), .trace_data_i(tdata), .trig_i(trig)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic push(input logic [31:0] d, input logic t);
    @(negedge clk); tvalid = 1'b1; tdata = d; trig = t;
    @(negedge clk); tvalid = 1'b0; trig = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    bus_read(A_DEPTH, rv); check("R1 depth", rv, TB_DEPTH);
    bus_read(A_STAT, rv);  check("R2 status after reset", rv, 32'h4);
    bus_read(A_WPTR, rv);  check("R2 wptr after reset", rv, 0);
    bus_read(A_RPTR, rv);  check("R2 rptr after reset", rv, 0);
    bus_read(A_CTRL, rv);  check("R2 ctrl after reset", rv, 0);
  endtask

  task automatic t_mode_gate;
    bus_write(A_MODE, 32'd2);
    bus_write(A_CTRL, 32'd1);
    for (int i = 0; i < 3; i++) push(32'h5000 + i, 1'b0);
    bus_read(A_WPTR, rv); check("R3 hw fifo mode stores nothing", rv, 0);
    bus_write(A_MODE, 32'd1);
    push(32'h5100, 1'b0);
    bus_read(A_WPTR, rv); check("R3 sw fifo mode stores nothing", rv, 0);
    bus_write(A_CTRL, 32'd0);
    bus_write(A_MODE, 32'd0);
    push(32'h5200, 1'b0);
    bus_read(A_WPTR, rv); check("R3 disabled stores nothing", rv, 0);
  endtask

  task automatic t_linear;
    bus_write(A_CTRL, 32'd1);
    bus_read(A_STAT, rv);  check("R10 ready low while running", rv, 32'h0);
    bus_read(A_RDATA, rv); check("R6 read while running", rv, 32'hFFFF_FFFF);
    for (int i = 0; i < 5; i++) push(32'hA000 + i, 1'b0);
    bus_read(A_WPTR, rv);  check("R3 circular capture", rv, 5);
    bus_write(A_FLUSH, 32'h1040);
    idle(4);
    bus_read(A_FLUSH, rv); check("R7 manual flush self clears", rv, 32'h1000);
    bus_read(A_STAT, rv);  check("R10 ready after stop", rv, 32'h4);
    push(32'hDEAD, 1'b0); push(32'hBEEF, 1'b0);
    bus_read(A_WPTR, rv);  check("R7 capture halted after flush", rv, 5);
    for (int i = 0; i < 5; i++) begin
      bus_read(A_RDATA, rv); check("R5 linear readback", rv, 32'hA000 + i);
    end
    bus_read(A_RPTR, rv);  check("R12 read pointer advanced", rv, 5);
    bus_read(A_RDATA, rv); check("R6 read past end", rv, 32'hFFFF_FFFF);
    bus_read(A_RPTR, rv);  check("R6 pointer held on empty read", rv, 5);
  endtask

  task automatic t_wrap_trigger;
    bus_write(A_FLUSH, 32'h1120);
    bus_write(A_TCNT, 32'd3);
    bus_write(A_CTRL, 32'd0);
    bus_write(A_CTRL, 32'd1);
    for (int i = 0; i < 14; i++) push(32'hB000 + i, 1'b0);
    bus_read(A_WPTR, rv);  check("R4 pointer wrapped", rv, 3);
    bus_read(A_STAT, rv);  check("R4 wrap flag while running", rv, 32'h1);
    push(32'hB00E, 1'b1);
    for (int i = 0; i < 6; i++) push(32'hB00F + i, 1'b0);
    idle(4);
    bus_read(A_STAT, rv);  check("R9 wrapped triggered ready", rv, 32'h7);
    bus_read(A_WPTR, rv);  check("R9 post count limits words", rv, 7);
    for (int i = 0; i < TB_DEPTH; i++) begin
      bus_read(A_RDATA, rv); check("R4 wrapped readback oldest first", rv, 32'hB002 + i);
    end
    bus_read(A_RPTR, rv);  check("R12 pointer modulo depth", rv, 7);
    bus_read(A_RDATA, rv); check("R6 read past full depth", rv, 32'hFFFF_FFFF);
  endtask

  task automatic t_trig_ignored;
    bus_write(A_CTRL, 32'd0);
    bus_write(A_FLUSH, 32'h0);
    bus_write(A_CTRL, 32'd1);
    bus_read(A_STAT, rv);  check("R11 re-enable clears triggered", rv, 32'h1);
    push(32'hC000, 1'b1);
    bus_read(A_STAT, rv);  check("R8 trigger ignored without enable bit", rv, 32'h1);
    bus_read(A_WPTR, rv);  check("R11 resumes at current pointer", rv, 8);
    bus_write(A_FLUSH, 32'h40);
    idle(4);
    bus_read(A_FLUSH, rv); check("R7 flush bit clears", rv, 32'h0);
    push(32'hC001, 1'b0);
    bus_read(A_WPTR, rv);  check("R7 capture continues without stop", rv, 9);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (WD_CYCLES) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=<%0d cycles", WD_CYCLES, WD_CYCLES);
    finish_run();
  end

  initial begin : main
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_mode_gate();
    t_linear();
    t_wrap_trigger();
    t_trig_ignored();
    idle(2);
    finish_run();
  end

endmodule